// File: doc/BRIEF.md
# Loop-Detect Status Debouncer, Four Channels

This block cleans up the loop-detect status bit of four line channels before the bit is reported onward. Each channel takes a raw status bit, samples it once per frame (a 125 µs strobe), and passes a sampled value to its filtered output only after that value has stayed unchanged for a programmed number of milliseconds. The millisecond count runs on a separate 1 ms strobe. Any change seen between two successive frame samples restarts the count.

The settling time is a single 4-bit value (0 to 15 ms) shared by all four channels. Each channel still keeps its own sample register, millisecond counter and filter state. Each channel runs a two-state machine. In ST_STABLE the output equals the held sample. In ST_PENDING a differing sample is waiting out the settling time. The transitions are: STABLE→PENDING on a sample change when the time is non-zero; STABLE→STABLE with an output update on a sample change when the time is zero; PENDING→STABLE without update when a new sample equals the output again; PENDING→STABLE with update when the count reaches the programmed time; PENDING→PENDING otherwise (a change to a still-differing value restarts the count here). Both strobes are one clock wide and come from outside the block.

Top module: `ldq_debounce_quad`

## Requirements
- R1: After reset every filtered output, every held sample and every millisecond count is zero.
- R2: The raw input is taken only in a cycle with `samp_tick` high; a pulse on `raw_in` that starts and ends between two sample strobes has no effect on `filt_out`.
- R3: A sample that differs from the previous sample restarts that channel's millisecond count at zero, and the output keeps its old value while the count restarts.
- R4: The count advances only in a cycle with `ms_tick` high. The output takes the held sample at the clock edge of the N-th counted `ms_tick` after the last change, where N is `dbnc_time`.
- R5: With `dbnc_time` equal to 0, the output takes the new sample at the same clock edge at which the sample strobe captures it.
- R6: The count stops at the programmed time and never wraps; while the input stays steady after an update, any number of further `ms_tick` pulses leave the output unchanged.
- R7: The four channels filter independently; bit i of `raw_in` drives only bit i of `filt_out`, and all channels use the one shared `dbnc_time`.
- R8: When a sample change and an `ms_tick` fall in the same cycle, the restart wins: the count is zero afterwards and that tick is not counted.
- R9: A new `dbnc_time` applies at once. A pending channel whose count is already at or above the new value updates its output at the next clock edge.
- R10: If the sample returns to the current output value before the settling time has run out, the pending update is cancelled and the output does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | One-cycle frame strobe, every 125 µs |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| raw_in | input | NUM_CH (4) | Raw loop-detect status, one bit per channel |
| dbnc_time | input | TIME_W (4) | Shared settling time in ms, 0 to 15 |
| filt_out | output | NUM_CH (4) | Debounced status, one bit per channel |

## Verification
Restarting on a sample change and advancing on a millisecond tick can fall in the same cycle. The bench provokes this by aligning the millisecond strobe with a frame strobe and changing a raw bit at exactly that sample. With a settling time of 1, the output must still hold its old value after that edge and must flip only at the following millisecond tick. The bench also runs long random stretches in which the strobe alignment, the raw bits and the shared time all vary. A behavioural reference model, written as a plain per-channel counter, is compared against the outputs on every clock.

// File: rtl/ldq_pkg.sv
package ldq_pkg;

    // Per-channel filter state
    typedef enum logic {
        ST_STABLE  = 1'b0,  // output equals held sample
        ST_PENDING = 1'b1   // differing sample waiting out the settling time
    } ldq_state_e;

endpackage

// File: rtl/ldq_sampler.sv
// Frame-rate sampler: holds the last sample and flags a change.
module ldq_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_tick,
    input  logic raw,
    output logic smp_q,
    output logic smp_nxt,
    output logic change
);

    always_comb begin
        change  = samp_tick && (raw != smp_q);
        smp_nxt = samp_tick ? raw : smp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            smp_q <= 1'b0;
        end else begin
            smp_q <= smp_nxt;
        end
    end

endmodule

// File: rtl/ldq_ms_counter.sv
// Millisecond settling counter: clear wins, saturates at the limit.
module ldq_ms_counter #(
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [TIME_W-1:0] limit,
    output logic [TIME_W-1:0] cnt_q,
    output logic              at_limit
);

    localparam logic [TIME_W-1:0] ONE = TIME_W'(1);

    logic [TIME_W-1:0] cnt_nxt;

    always_comb begin
        if (clr) begin
            cnt_nxt = '0;
        end else if (adv && (cnt_q < limit)) begin
            cnt_nxt = cnt_q + ONE;
        end else begin
            cnt_nxt = cnt_q;
        end
        at_limit = (cnt_nxt >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/ldq_chan_fsm.sv
// Per-channel filter state machine and output latch.
module ldq_chan_fsm
    import ldq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    input  logic smp_nxt,
    input  logic at_limit,
    output logic filt_q,
    output logic pending
);

    ldq_state_e state_q;
    ldq_state_e state_d;
    logic       upd;

    always_comb begin
        state_d = state_q;
        upd     = 1'b0;
        unique case (state_q)
            ST_STABLE: begin
                if (change) begin
                    if (at_limit) begin
                        upd = 1'b1;
                    end else begin
                        state_d = ST_PENDING;
                    end
                end
            end
            ST_PENDING: begin
                if (change && (smp_nxt == filt_q)) begin
                    state_d = ST_STABLE;
                end else if (at_limit) begin
                    upd     = 1'b1;
                    state_d = ST_STABLE;
                end
            end
            default: begin
                state_d = ST_STABLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STABLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
        end else if (upd) begin
            filt_q <= smp_nxt;
        end
    end

    assign pending = (state_q == ST_PENDING);

endmodule

// File: rtl/ldq_debounce_quad.sv
// Four-channel loop-detect debouncer with shared settling time.
module ldq_debounce_quad #(
    parameter int NUM_CH = 4,
    parameter int TIME_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_tick,
    input  logic              ms_tick,
    input  logic [NUM_CH-1:0] raw_in,
    input  logic [TIME_W-1:0] dbnc_time,
    output logic [NUM_CH-1:0] filt_out
);

    logic [NUM_CH-1:0]             smp_vec;
    logic [NUM_CH-1:0][TIME_W-1:0] cnt_vec;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic smp_nxt;
        logic change;
        logic pending;
        logic at_limit;

        ldq_sampler u_smp (
            .clk       (clk),
            .rst_n     (rst_n),
            .samp_tick (samp_tick),
            .raw       (raw_in[ch]),
            .smp_q     (smp_vec[ch]),
            .smp_nxt   (smp_nxt),
            .change    (change)
        );

        ldq_ms_counter #(.TIME_W(TIME_W)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (change || !pending),
            .adv      (ms_tick && pending),
            .limit    (dbnc_time),
            .cnt_q    (cnt_vec[ch]),
            .at_limit (at_limit)
        );

        ldq_chan_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .change   (change),
            .smp_nxt  (smp_nxt),
            .at_limit (at_limit),
            .filt_q   (filt_out[ch]),
            .pending  (pending)
        );
    end

endmodule

// File: rtl/ldq_debounce_chk.sv
// Property checker bound to the debouncer top.
module ldq_debounce_chk #(
    parameter int NUM_CH = 4,
    parameter int TIME_W = 4
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          samp_tick,
    input logic                          ms_tick,
    input logic [NUM_CH-1:0]             raw_in,
    input logic [TIME_W-1:0]             dbnc_time,
    input logic [NUM_CH-1:0]             filt_out,
    input logic [NUM_CH-1:0]             smp_q,
    input logic [NUM_CH-1:0][TIME_W-1:0] cnt_q
);

    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (filt_out == '0 && smp_q == '0));

    a_r2_hold_between_frames: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_tick |=> $stable(smp_q));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_p
        a_r3_change_restarts: assert property (@(posedge clk) disable iff (!rst_n)
            (samp_tick && raw_in[i] != smp_q[i]) |=> (cnt_q[i] == '0));

        a_r4_update_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
            (filt_out[i] != $past(filt_out[i])) |-> (cnt_q[i] >= $past(dbnc_time)));

        a_r5_zero_time_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (samp_tick && dbnc_time == '0) |=> (filt_out[i] == $past(raw_in[i])));

        a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q[i] >= dbnc_time) |=> (cnt_q[i] <= $past(cnt_q[i])));

        a_r8_restart_beats_tick: assert property (@(posedge clk) disable iff (!rst_n)
            (samp_tick && ms_tick && raw_in[i] != smp_q[i]) |=> (cnt_q[i] == '0));
    end

endmodule

bind ldq_debounce_quad ldq_debounce_chk #(
    .NUM_CH (NUM_CH),
    .TIME_W (TIME_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_tick (samp_tick),
    .ms_tick   (ms_tick),
    .raw_in    (raw_in),
    .dbnc_time (dbnc_time),
    .filt_out  (filt_out),
    .smp_q     (smp_vec),
    .cnt_q     (cnt_vec)
);

// File: tb/tb_ldq_debounce_quad.sv
`timescale 1ns/1ps
module tb_ldq_debounce_quad;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [NCH-1:0] raw_in = '0;
    logic [3:0]  dbnc_time = 4'd0;
    logic [NCH-1:0] filt_out;
    logic [31:0] cyc = 0;
    int          ms_off = 2;
    logic        samp_tick;
    logic        ms_tick;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    // Scaled strobes: frame every 4 clocks, millisecond every 32 clocks
    always @(posedge clk) cyc <= cyc + 1;
    assign samp_tick = (cyc % 4) == 0;
    assign ms_tick   = (cyc % 32) == ms_off;

    ldq_debounce_quad dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .samp_tick (samp_tick),
        .ms_tick   (ms_tick),
        .raw_in    (raw_in),
        .dbnc_time (dbnc_time),
        .filt_out  (filt_out)
    );

    // Behavioural reference: free-running counter per channel
    int m_cnt [NCH];
    bit m_smp [NCH];
    bit m_out [NCH];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_cnt[c] = 0; m_smp[c] = 0; m_out[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (samp_tick && raw_in[c] != m_smp[c]) m_cnt[c] = 0;
                else if (ms_tick && m_cnt[c] < int'(dbnc_time)) m_cnt[c]++;
                if (samp_tick) m_smp[c] = raw_in[c];
                if (m_cnt[c] >= int'(dbnc_time)) m_out[c] = m_smp[c];
            end
        end
    end

    function automatic logic [NCH-1:0] model_vec();
        logic [NCH-1:0] v;
        for (int c = 0; c < NCH; c++) v[c] = m_out[c];
        return v;
    endfunction

    task automatic chk(input string req, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the reference (R4 R7 and all others)
    always @(negedge clk) begin
        if (rst_n && !finished) chk("R7 reference compare", filt_out, model_vec());
    end

    task automatic wait_samp();
        @(negedge clk);
        while (!samp_tick) @(negedge clk);
    endtask

    task automatic wait_ms(input int n);
        repeat (n) begin
            @(negedge clk);
            while (!ms_tick) @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic settle();
        wait_ms(int'(dbnc_time) + 2);
    endtask

    task automatic finish_run();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", filt_out, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", filt_out, '0);

        // R5: zero time, output follows the sample on the capturing edge
        dbnc_time = 4'd0;
        wait_samp();
        raw_in = 4'b1011;
        @(negedge clk);
        chk("R5 zero-time follow", filt_out, 4'b1011);
        raw_in = 4'b0000;
        wait_samp();
        @(negedge clk);
        chk("R5 zero-time follow back", filt_out, 4'b0000);

        // R4: exact latency of three counted ticks
        dbnc_time = 4'd3;
        settle();
        wait_samp();
        raw_in[2] = 1'b1;
        wait_ms(2);
        chk("R4 before limit", filt_out, 4'b0000);
        wait_ms(1);
        chk("R4 at limit", filt_out, 4'b0100);

        // R6: stays put for many further ticks
        wait_ms(20);
        chk("R6 hold after update", filt_out, 4'b0100);

        // R3: a change in the middle restarts the count
        raw_in[2] = 1'b0;
        settle();
        chk("R3 setup", filt_out, 4'b0000);
        wait_samp();
        raw_in[2] = 1'b1;
        wait_ms(2);
        wait_samp();
        raw_in[2] = 1'b0;
        wait_samp();
        raw_in[2] = 1'b1;
        wait_ms(2);
        chk("R3 restarted count", filt_out, 4'b0000);
        wait_ms(1);
        chk("R3 after restart", filt_out, 4'b0100);

        // R10: return to the output value cancels the update
        wait_samp();
        raw_in[3] = 1'b1;
        wait_ms(2);
        wait_samp();
        raw_in[3] = 1'b0;
        wait_ms(5);
        chk("R10 cancelled update", filt_out, 4'b0100);

        // R2: glitch between sample strobes is ignored
        @(negedge clk);
        while ((cyc % 4) != 2) @(negedge clk);
        raw_in[1] = 1'b1;
        @(negedge clk);
        raw_in[1] = 1'b0;
        wait_ms(5);
        chk("R2 inter-frame glitch", filt_out, 4'b0100);

        // R7: independent channels, shared time
        raw_in = 4'b0000;
        dbnc_time = 4'd2;
        settle();
        wait_samp();
        raw_in[0] = 1'b1;
        wait_ms(1);
        wait_samp();
        raw_in[3] = 1'b1;
        wait_ms(1);
        chk("R7 ch0 done ch3 pending", filt_out, 4'b0001);
        wait_ms(1);
        chk("R7 both done", filt_out, 4'b1001);

        // R9: lowering the time releases a pending channel at once
        raw_in = 4'b0000;
        dbnc_time = 4'd10;
        settle();
        wait_samp();
        raw_in[1] = 1'b1;
        wait_ms(4);
        chk("R9 pending", filt_out, 4'b0000);
        dbnc_time = 4'd2;
        @(negedge clk);
        chk("R9 lowered time", filt_out, 4'b0010);

        // R8: change and tick in the same cycle, restart wins
        raw_in = 4'b0000;
        dbnc_time = 4'd1;
        settle();
        ms_off = 0;
        @(negedge clk);
        while (!(ms_tick && samp_tick)) @(negedge clk);
        raw_in[1] = 1'b1;
        @(negedge clk);
        chk("R8 coincident tick not counted", filt_out, 4'b0000);
        wait_ms(1);
        chk("R8 next tick counts", filt_out, 4'b0010);

        // R6: maximum time, long hold
        raw_in = 4'b0000;
        dbnc_time = 4'd15;
        settle();
        wait_samp();
        raw_in[0] = 1'b1;
        wait_ms(14);
        chk("R6 max time before", filt_out, 4'b0000);
        wait_ms(1);
        chk("R6 max time reached", filt_out, 4'b0001);
        wait_ms(18);
        chk("R6 no wrap", filt_out, 4'b0001);

        // Random mix checked by the reference every clock
        for (int k = 0; k < 40000; k++) begin
            @(negedge clk);
            if (($urandom % 48) == 0) raw_in[$urandom % NCH] ^= 1'b1;
            if (($urandom % 3000) == 0) dbnc_time = 4'($urandom % 16);
            if (($urandom % 5000) == 0) ms_off = int'($urandom % 3);
        end

        finish_run();
    end

endmodule